// File: doc/BRIEF.md
# Dual-Clock Replay FIFO

This block is a first-in first-out buffer whose writer and reader run on unrelated clocks. Words of `DATA_W` bits are stored in a RAM of `2**ADDR_W` entries. The read port works in look-ahead fashion: the oldest stored word is already present on the read data bus whenever the ready output is low. A read enable taken at a read-clock edge moves the bus on to the next word. The block sends its read and write pointers across the clock boundary as gray codes, each through a two-flop synchroniser. From those pointers it derives a half-full flag and programmable almost-empty and almost-full flags.

A rewind request, sampled on the read clock, sets the read pointer back to RAM location zero and leaves the write pointer unchanged. Everything written since reset can then be read out a second time. The replay is only meaningful if no more than the RAM depth has been written since reset. After a rewind the flags settle at different times. The half-full flag is a combinational function of both pointers, so it changes at the rewind edge itself. The almost-empty flag changes on the second read-clock edge. The almost-full flag changes on the second write-clock edge, once the rewound pointer has crossed the synchroniser.

The deployed geometry is 8192 words of 18 bits (`ADDR_W` = 13). The parameter default is kept smaller so that default elaboration stays light.

Top module: `replay_fifo`

## Requirements
- R1: While `rst_n` is low, the outputs are `ready_n`=1, `almost_empty_n`=0, `almost_full_n`=1 and `half_full_n`=1.
- R2: After the first word is written into an empty FIFO, `ready_n` goes low and that word appears on `rd_data` without any pulse on `rd_en_n`.
- R3: Words leave in the order they were written. A word leaves at a read-clock edge only when `rd_en_n`=0 and `ready_n`=0. Without that, `rd_data` holds its value.
- R4: Once `2**ADDR_W` words are stored, further writes are ignored until a word is read.
- R5: `almost_full_n` is 0 exactly when the write-side occupancy (written minus read, as seen through the synchroniser) is at least `2**ADDR_W - AF_OFF`.
- R6: `half_full_n` is 0 exactly when the written count minus the read count exceeds `2**ADDR_W / 2`. It is combinational in the two pointers.
- R7: `almost_empty_n` is a read-clock register. It is 0 when the occupancy seen on the read side is at most `AE_OFF`.
- R8: `rewind_n`=0 at a read-clock edge sets the read pointer to location zero, and `ready_n` is 1 after that edge.
- R9: On the next read-clock edge after the rewind, `ready_n` returns to 0 with the word from location zero on `rd_data` and no read enable. Later reads replay the stored words in their written order.
- R10: `half_full_n` reflects the rewound read pointer directly after the rewind edge.
- R11: `almost_empty_n` reflects the rewind on the second read-clock edge after the rewind edge, and not before.
- R12: The write pointer is not changed by a rewind. `almost_full_n` reflects the rewind on the second write-clock edge after the rewind edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| wr_data | input | DATA_W | Word to store |
| wr_en_n | input | 1 | Write enable, active low, sampled on wr_clk |
| rd_en_n | input | 1 | Read enable, active low, sampled on rd_clk |
| rewind_n | input | 1 | Rewind request, active low, sampled on rd_clk |
| rd_data | output | DATA_W | Oldest unread word |
| ready_n | output | 1 | Low while rd_data holds a valid word |
| almost_empty_n | output | 1 | Low when few words are stored (read domain) |
| almost_full_n | output | 1 | Low when nearly full (write domain) |
| half_full_n | output | 1 | Low when more than half the depth is stored |

## Verification
The bench fills the FIFO in steps chosen to land on each flag threshold and one word either side of it. This separates an off-by-one compare from a correct one. It also writes one word more than the depth while nothing is read, to show whether the surplus word is dropped. A partial drain checks read order and output hold. A rewind taken at low occupancy then drives the three flags toward opposite levels. Sampling them one and two edges after the rewind, on their own clocks, shows whether each one updates at its own time. A full replay of every written word shows that the rewind left the write pointer and the stored data intact.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;

    // binary to reflected gray code
    function automatic logic [31:0] to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // gray code back to binary: each bit is the parity of the bits above it
    function automatic logic [31:0] from_gray(input logic [31:0] g);
        logic [31:0] b;
        for (int i = 0; i < 32; i++) begin
            b[i] = ^(g >> i);
        end
        return b;
    endfunction

endpackage

// File: rtl/rf_sync.sv
module rf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = d;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/rf_mem.sv
module rf_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rf_wr_side.sv
module rf_wr_side
    import replay_fifo_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int AF_OFF = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_n,
    input  logic [ADDR_W:0] rgray_sync,
    output logic            we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0] wptr,
    output logic [ADDR_W:0] wgray,
    output logic            almost_full_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
    } wst_t;

    wst_t st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic          full;

    always_comb begin
        rbin          = PW'(from_gray(32'(rgray_sync)));
        occ           = st_q.ptr - rbin;
        full          = (occ == PW'(DEPTH));
        we            = !wr_en_n && !full;
        almost_full_n = !(occ >= PW'(DEPTH - AF_OFF));
        st_d          = st_q;
        if (we) st_d.ptr = st_q.ptr + PW'(1);
        st_d.gray     = PW'(to_gray(32'(st_d.ptr)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr = st_q.ptr[ADDR_W-1:0];
    assign wptr  = st_q.ptr;
    assign wgray = st_q.gray;

    // R4: a full FIFO accepts no write
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> st_q.ptr == $past(st_q.ptr));

    // R4: occupancy never exceeds the depth
    p_occ_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));
endmodule

// File: rtl/rf_rd_side.sv
module rf_rd_side
    import replay_fifo_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4,
    parameter int AE_OFF = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_n,
    input  logic              rewind_n,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] ram_data,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready_n,
    output logic              almost_empty_n
);
    localparam int PW = ADDR_W + 1;

    typedef struct packed {
        logic [PW-1:0]     ptr;
        logic [PW-1:0]     gray;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic              ae_n;
    } rst_t;

    rst_t st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] nptr;
    logic          take;

    always_comb begin
        wbin      = PW'(from_gray(32'(wgray_sync)));
        occ       = wbin - st_q.ptr;
        take      = !rd_en_n && st_q.valid;
        nptr      = take ? st_q.ptr + PW'(1) : st_q.ptr;
        raddr     = nptr[ADDR_W-1:0];
        st_d      = st_q;
        st_d.ae_n = !(occ <= PW'(AE_OFF));
        if (!rewind_n) begin
            st_d.ptr   = '0;
            st_d.valid = 1'b0;
        end else begin
            st_d.ptr   = nptr;
            st_d.valid = (wbin != nptr);
            st_d.data  = ram_data;
        end
        st_d.gray = PW'(to_gray(32'(st_d.ptr)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rptr           = st_q.ptr;
    assign rgray          = st_q.gray;
    assign rd_data        = st_q.data;
    assign ready_n        = !st_q.valid;
    assign almost_empty_n = st_q.ae_n;

    // R8: a rewind lands the pointer on location zero
    p_rewind_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind_n |=> st_q.ptr == '0 && ready_n);

    // R3: a held word stays put while no read is requested
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && rd_en_n && rewind_n) |=> (st_q.valid && $stable(st_q.data)));

    // R3: outside a rewind the pointer advances by at most one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rewind_n |=> (st_q.ptr - $past(st_q.ptr)) <= PW'(1));
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 10,
    parameter int AE_OFF = 7,
    parameter int AF_OFF = 7
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic              rewind_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready_n,
    output logic              almost_empty_n,
    output logic              almost_full_n,
    output logic              half_full_n
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] ram_data;
    logic [PW-1:0]     wptr, wgray, wgray_sync;
    logic [PW-1:0]     rptr, rgray, rgray_sync;
    logic [PW-1:0]     fill;

    rf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .raddr(raddr), .rdata(ram_data)
    );

    rf_wr_side #(.ADDR_W(ADDR_W), .AF_OFF(AF_OFF)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rgray_sync(rgray_sync),
        .we(we), .waddr(waddr), .wptr(wptr), .wgray(wgray),
        .almost_full_n(almost_full_n)
    );

    rf_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .AE_OFF(AE_OFF)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
        .wgray_sync(wgray_sync), .ram_data(ram_data), .raddr(raddr),
        .rptr(rptr), .rgray(rgray), .rd_data(rd_data), .ready_n(ready_n),
        .almost_empty_n(almost_empty_n)
    );

    rf_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wgray_sync));
    rf_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rgray_sync));

    // half-full: combinational across both pointers, no clock
    always_comb begin
        fill        = wptr - rptr;
        half_full_n = !(fill > PW'(DEPTH / 2));
    end

    // R10: right after a rewind edge the half-full level follows the write pointer alone
    p_half_after_rewind_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !rewind_n |=> ##0 (half_full_n == !(wptr > PW'(DEPTH / 2))));
endmodule

// File: tb/sim_replay_fifo.sv
`timescale 1ns/100ps
module sim_replay_fifo;
    localparam int WPER   = 10;
    localparam int RPER   = 16;
    localparam int DW     = 18;
    localparam int AW     = 4;
    localparam int DEPTH  = 1 << AW;

    logic wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic wr_en_n = 1'b1, rd_en_n = 1'b1, rewind_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic ready_n, almost_empty_n, almost_full_n, half_full_n;

    int n_checks = 0;
    int n_fail   = 0;

    replay_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_OFF(7), .AF_OFF(7)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_data(wr_data),
        .wr_en_n(wr_en_n), .rd_en_n(rd_en_n), .rewind_n(rewind_n),
        .rd_data(rd_data), .ready_n(ready_n), .almost_empty_n(almost_empty_n),
        .almost_full_n(almost_full_n), .half_full_n(half_full_n)
    );

    always #(WPER/2) wr_clk = ~wr_clk;
    always #(RPER/2) rd_clk = ~rd_clk;

    function automatic int wv(int k);
        return (k * 4673 + 97) & 'h3FFFF;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic write_words(int first, int count);
        for (int i = 0; i < count; i++) begin
            @(negedge wr_clk);
            wr_data = DW'(wv(first + i));
            wr_en_n = 1'b0;
        end
        @(negedge wr_clk);
        wr_en_n = 1'b1;
    endtask

    task automatic wait_rd(int n);
        for (int i = 0; i < n; i++) @(negedge rd_clk);
    endtask

    task automatic wait_wr(int n);
        for (int i = 0; i < n; i++) @(negedge wr_clk);
    endtask

    // read 'count' words expecting indices first.., one per rd_clk edge
    task automatic read_words(int first, int count, string req);
        for (int i = 0; i < count; i++) begin
            int n = 0;
            @(negedge rd_clk);
            while (ready_n && n < 50) begin
                @(negedge rd_clk);
                n++;
            end
            check(req, "ready before read", int'(ready_n), 0);
            check(req, "read word", int'(rd_data), wv(first + i));
            rd_en_n = 1'b0;
        end
        @(negedge rd_clk);
        rd_en_n = 1'b1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        #33;
        check("R1", "ready_n in reset", int'(ready_n), 1);
        check("R1", "almost_empty_n in reset", int'(almost_empty_n), 0);
        check("R1", "almost_full_n in reset", int'(almost_full_n), 1);
        check("R1", "half_full_n in reset", int'(half_full_n), 1);
        #3 rst_n = 1'b1;
    endtask

    task automatic t_first_word();
        write_words(0, 1);
        wait_rd(6);
        check("R2", "ready_n after first write", int'(ready_n), 0);
        check("R2", "first word shown", int'(rd_data), wv(0));
        check("R7", "almost_empty_n with one word", int'(almost_empty_n), 0);
    endtask

    task automatic t_fill();
        write_words(1, 7);                 // 8 stored
        wait_wr(1);
        check("R5", "almost_full_n at 8", int'(almost_full_n), 1);
        check("R6", "half_full_n at 8", int'(half_full_n), 1);
        wait_rd(6);
        check("R7", "almost_empty_n at 8", int'(almost_empty_n), 1);
        write_words(8, 1);                 // 9 stored
        check("R5", "almost_full_n at 9", int'(almost_full_n), 0);
        check("R6", "half_full_n at 9", int'(half_full_n), 0);
        write_words(9, 8);                 // index 16 must be dropped
    endtask

    task automatic t_partial_read();
        read_words(0, 10, "R3");
        wait_rd(3);
        check("R3", "held word without read", int'(rd_data), wv(10));
        wait_rd(2);
        check("R3", "still held", int'(rd_data), wv(10));
        check("R6", "half_full_n at 6", int'(half_full_n), 1);
        check("R7", "almost_empty_n at 6", int'(almost_empty_n), 0);
        wait_wr(4);
        check("R5", "almost_full_n at 6", int'(almost_full_n), 1);
    endtask

    task automatic t_rewind();
        @(negedge rd_clk);
        rewind_n = 1'b0;
        @(posedge rd_clk);
        #1;
        check("R8", "ready_n after rewind edge", int'(ready_n), 1);
        check("R10", "half_full_n after rewind edge", int'(half_full_n), 0);
        check("R11", "almost_empty_n one edge after", int'(almost_empty_n), 0);
        check("R12", "almost_full_n before crossing", int'(almost_full_n), 1);
        fork
            begin
                @(negedge rd_clk);
                rewind_n = 1'b1;
                @(posedge rd_clk);
                #1;
                check("R11", "almost_empty_n two edges after", int'(almost_empty_n), 1);
                check("R9", "ready_n after setup", int'(ready_n), 0);
                check("R9", "location zero shown", int'(rd_data), wv(0));
            end
            begin
                @(posedge wr_clk);
                #1;
                check("R12", "almost_full_n one write edge after", int'(almost_full_n), 1);
                @(posedge wr_clk);
                #1;
                check("R12", "almost_full_n two write edges after", int'(almost_full_n), 0);
            end
        join
        read_words(0, DEPTH, "R9");
        wait_rd(6);
        check("R4", "no word beyond depth", int'(ready_n), 1);
        check("R7", "almost_empty_n after drain", int'(almost_empty_n), 0);
    endtask

    initial begin
        #(RPER * 10000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        t_reset();
        t_first_word();
        t_fill();
        t_partial_read();
        t_rewind();
        finish_sim();
    end
endmodule